// File: doc/BRIEF.md
# Shadow Scan-State Access Node Chain

This block gives software direct reach into pieces of live processor state. It keeps a row of access nodes. Each node pairs one live state register, which the protected functional logic normally updates, with a shadow scan register of the same width. Commands arrive on a single command port, and each one targets one node through a select field. A command can write a data word into a node's shadow, return a node's shadow on the read-data port, or exchange the shadow and live contents of a node.

The block also runs an atomic test command. It first swaps the node's shadow into the live register, which applies a stored pattern. It then lets the functional logic clock the live register once. Finally it swaps again, so the shadow now holds the response and the live register is back to what it held before. While this sequence runs, the block raises a busy flag and drops every incoming command. A command whose select value names no existing node changes no state and raises an error pulse instead.

Top module: `shadow_scan_access`

## Requirements
- R1: After reset, every live register and every shadow register is zero, and `busy`, `err` and `rd_valid` are low.
- R2: A LOAD command (`cmd_op` = 3'd1) accepted at a clock edge writes `cmd_data` into the selected node's shadow at that edge. Other shadows and all live registers are not changed by the command.
- R3: A READ command (`cmd_op` = 3'd2) accepted at an edge sets `rd_valid` high for the one following cycle, with `rd_data` equal to the selected shadow as it was at that edge.
- R4: A SWAP command (`cmd_op` = 3'd3) accepted at an edge exchanges the selected node's live and shadow contents at that edge. The swap takes priority over a functional update of that node.
- R5: A TEST command (`cmd_op` = 3'd4) raises `busy` for exactly three cycles. On those three edges the block performs, in order: a swap, a capture of `func_d` into the live register (this happens even when `func_en` is low), and a swap. Afterwards the shadow holds the captured response and the live register holds its pre-test value.
- R6: While `busy` is high, commands are ignored. No shadow, live or read state changes because of them, and `err` stays low.
- R7: An accepted LOAD, READ, SWAP or TEST whose `cmd_sel` is not below NODES has no effect, and `err` is high for the one following cycle. Codes 3'd0 and 3'd5 to 3'd7 never have an effect and never raise `err`.
- R8: In the two swap cycles of a test, no node's live register takes a functional update. In the capture cycle, nodes other than the tested one update normally.
- R9: Outside of swaps and test swap cycles, a node's live register loads its `func_d` slice at each edge where its `func_en` bit is high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_sel | input | SEL_W | Target node index |
| cmd_data | input | W | Word for LOAD |
| rd_data | output | W | Shadow value returned by READ |
| rd_valid | output | 1 | rd_data valid this cycle |
| busy | output | 1 | Test sequence in progress |
| err | output | 1 | Previous command selected a missing node |
| func_en | input | NODES | Per-node functional update enable |
| func_d | input | NODES*W | Functional next-state values, node i at bits i*W |
| live_q | output | NODES*W | Live register contents, node i at bits i*W |

## Verification
The bench builds the block with NODES=5 and SEL_W=3. Because the node count is not a power of two, the select values 5, 6 and 7 can be driven, which exercises the out-of-range error path on every command code. An 8-bit width keeps the test response easy to tell apart from the applied pattern. The bench's functional logic is a rotate-and-xor of each node's own live value, so the captured response depends on the pattern that was swapped in. Random commands land during busy windows and on back-to-back cycles, and every select value gets hit often.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_READ = 3'd2,
    OP_SWAP = 3'd3,
    OP_TEST = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SWAP_IN,
    PH_CAPTURE,
    PH_SWAP_OUT
  } phase_e;

  function automatic logic op_targets_node(logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_READ) || (op == OP_SWAP) || (op == OP_TEST);
  endfunction
endpackage

// File: rtl/shadow_seq.sv
module shadow_seq #(
  parameter int NODES = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_sel,
  output logic [NODES-1:0] ld_vec,
  output logic [NODES-1:0] swap_vec,
  output logic [NODES-1:0] cap_vec,
  output logic             hold_all,
  output logic             rd_fire,
  output logic             busy,
  output logic             err
);
  import shadow_pkg::*;

  phase_e           ph;
  logic [SEL_W-1:0] tsel;
  logic             accept;
  logic             in_range;
  logic             good_cmd;
  logic [NODES-1:0] cmd_hot;
  logic [NODES-1:0] tst_hot;

  function automatic logic [NODES-1:0] decode_sel(logic [SEL_W-1:0] s);
    logic [NODES-1:0] v;
    for (int i = 0; i < NODES; i++) v[i] = (32'(s) == i);
    return v;
  endfunction

  assign accept   = cmd_valid && (ph == PH_IDLE);
  assign in_range = (32'(cmd_sel) < NODES);
  assign good_cmd = accept && in_range;
  assign cmd_hot  = decode_sel(cmd_sel);
  assign tst_hot  = decode_sel(tsel);
  assign busy     = (ph != PH_IDLE);
  assign hold_all = (ph == PH_SWAP_IN) || (ph == PH_SWAP_OUT);

  always_comb begin
    ld_vec   = '0;
    swap_vec = '0;
    cap_vec  = '0;
    rd_fire  = 1'b0;
    if (good_cmd) begin
      case (cmd_op)
        OP_LOAD: ld_vec   = cmd_hot;
        OP_SWAP: swap_vec = cmd_hot;
        OP_READ: rd_fire  = 1'b1;
        default: ;
      endcase
    end
    if (hold_all)           swap_vec = tst_hot;
    if (ph == PH_CAPTURE)   cap_vec  = tst_hot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      tsel <= '0;
      err  <= 1'b0;
    end else begin
      err <= accept && !in_range && op_targets_node(cmd_op);
      case (ph)
        PH_IDLE: if (good_cmd && cmd_op == OP_TEST) begin
          ph   <= PH_SWAP_IN;
          tsel <= cmd_sel;
        end
        PH_SWAP_IN:  ph <= PH_CAPTURE;
        PH_CAPTURE:  ph <= PH_SWAP_OUT;
        default:     ph <= PH_IDLE;
      endcase
    end
  end

  // R5: the test phases advance in fixed order
  p_phase_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SWAP_IN) |=> (ph == PH_CAPTURE));
  p_phase_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_CAPTURE) |=> (ph == PH_SWAP_OUT));
  p_phase_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SWAP_OUT) |=> (ph == PH_IDLE));
  // R4: at most one node exchanges state per cycle
  p_one_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(swap_vec));
  // R6: no shadow write while a test runs
  p_no_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ld_vec == '0) && !rd_fire);
endmodule

// File: rtl/shadow_node.sv
module shadow_node #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         swap,
  input  logic         cap,
  input  logic         hold,
  input  logic         fen,
  input  logic [W-1:0] fd,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] live,
  output logic [W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else if (swap) begin
      live   <= shadow;
      shadow <= live;
    end else begin
      if (ld) shadow <= ld_data;
      if (cap || (fen && !hold)) live <= fd;
    end
  end

  // R4: a swap exchanges the two registers
  p_swap_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (live == $past(shadow)) && (shadow == $past(live)));
  // R8: swap cycles freeze the live state of uninvolved nodes
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !swap) |=> $stable(live));
  // R2: shadow moves only on load or swap
  p_shadow_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !swap) |=> $stable(shadow));
endmodule

// File: rtl/shadow_scan_access.sv
module shadow_scan_access #(
  parameter int NODES = 4,
  parameter int W     = 16,
  parameter int SEL_W = $clog2(NODES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [W-1:0]       cmd_data,
  output logic [W-1:0]       rd_data,
  output logic               rd_valid,
  output logic               busy,
  output logic               err,
  input  logic [NODES-1:0]   func_en,
  input  logic [NODES*W-1:0] func_d,
  output logic [NODES*W-1:0] live_q
);
  logic [NODES-1:0] ld_vec, swap_vec, cap_vec;
  logic             hold_all, rd_fire;
  logic [W-1:0]     shadow_w [NODES];
  logic [W-1:0]     rd_mux;

  shadow_seq #(.NODES(NODES), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .ld_vec(ld_vec), .swap_vec(swap_vec),
    .cap_vec(cap_vec), .hold_all(hold_all), .rd_fire(rd_fire),
    .busy(busy), .err(err)
  );

  for (genvar g = 0; g < NODES; g++) begin : g_node
    shadow_node #(.W(W)) u_node (
      .clk(clk), .rst_n(rst_n), .ld(ld_vec[g]), .swap(swap_vec[g]),
      .cap(cap_vec[g]), .hold(hold_all), .fen(func_en[g]),
      .fd(func_d[g*W +: W]), .ld_data(cmd_data),
      .live(live_q[g*W +: W]), .shadow(shadow_w[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NODES; i++)
      if (32'(cmd_sel) == i) rd_mux = shadow_w[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_mux;
    end
  end

  // R3: read data appears only after an accepted read
  p_rdv_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_fire));
  // R5: busy lasts exactly three cycles
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> busy ##1 busy ##1 busy ##1 !busy);
endmodule

// File: tb/tb_shadow_scan_access.sv
module tb_shadow_scan_access;
  localparam int NODES = 5;
  localparam int W     = 8;
  localparam int SEL_W = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic [2:0]         cmd_op = '0;
  logic [SEL_W-1:0]   cmd_sel = '0;
  logic [W-1:0]       cmd_data = '0;
  logic [W-1:0]       rd_data;
  logic               rd_valid, busy, err;
  logic [NODES-1:0]   func_en = '0;
  logic [NODES*W-1:0] func_d;
  logic [NODES*W-1:0] live_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shadow_scan_access #(.NODES(NODES), .W(W), .SEL_W(SEL_W)) dut (.*);

  function automatic logic [W-1:0] resp(logic [W-1:0] x, int n);
    return {x[W-2:0], x[W-1]} ^ W'(8'h3C + n);
  endfunction

  for (genvar g = 0; g < NODES; g++) begin : g_fn
    assign func_d[g*W +: W] = resp(live_q[g*W +: W], g);
  end

  // reference state
  logic [W-1:0] mlive [NODES];
  logic [W-1:0] msh   [NODES];
  int           mph, mtsel;
  logic [W-1:0] mrd;
  logic         mrdv, merr;

  always @(posedge clk) begin
    logic [W-1:0] nl [NODES];
    logic [W-1:0] ns [NODES];
    logic [W-1:0] t;
    int s;
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin mlive[i] <= '0; msh[i] <= '0; end
      mph <= 0; mtsel <= 0; mrd <= '0; mrdv <= 1'b0; merr <= 1'b0;
    end else begin
      nl = mlive; ns = msh;
      for (int i = 0; i < NODES; i++)
        if (func_en[i] && !(mph == 1 || mph == 3)) nl[i] = resp(mlive[i], i);
      mrdv <= 1'b0; merr <= 1'b0;
      s = int'(cmd_sel);
      case (mph)
        0: if (cmd_valid) begin
          if (cmd_op >= 3'd1 && cmd_op <= 3'd4 && s >= NODES) merr <= 1'b1;
          else if (s < NODES) begin
            case (cmd_op)
              3'd1: ns[s] = cmd_data;
              3'd2: begin mrd <= msh[s]; mrdv <= 1'b1; end
              3'd3: begin nl[s] = msh[s]; ns[s] = mlive[s]; end
              3'd4: begin mph <= 1; mtsel <= s; end
              default: ;
            endcase
          end
        end
        1, 3: begin
          t = nl[mtsel]; nl[mtsel] = msh[mtsel]; ns[mtsel] = mlive[mtsel];
          mph <= (mph == 1) ? 2 : 0;
        end
        default: begin nl[mtsel] = resp(mlive[mtsel], mtsel); mph <= 3; end
      endcase
      for (int i = 0; i < NODES; i++) begin mlive[i] <= nl[i]; msh[i] <= ns[i]; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5/R6 busy", 32'(busy), 32'(mph != 0));
    chk("R7 err", 32'(err), 32'(merr));
    chk("R3 rd_valid", 32'(rd_valid), 32'(mrdv));
    if (mrdv) chk("R3 rd_data", 32'(rd_data), 32'(mrd));
    for (int i = 0; i < NODES; i++)
      chk("R2/R4/R8/R9 live", 32'(live_q[i*W +: W]), 32'(mlive[i]));
  endtask

  task automatic step(logic v, logic [2:0] op, logic [SEL_W-1:0] sel,
                      logic [W-1:0] d, logic [NODES-1:0] fen);
    @(negedge clk);
    compare_all();
    cmd_valid = v; cmd_op = op; cmd_sel = sel; cmd_data = d; func_en = fen;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 live zero", 32'(live_q == '0), 32'd1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);
    step(1, 3'd2, 3, 8'h00, '0);
    step(0, 0, 0, 0, '0);
    chk("R1 shadow zero", 32'(rd_data), 0);

    // load, read back, swap
    step(1, 3'd1, 2, 8'hA5, '0);
    step(1, 3'd2, 2, 8'h00, '0);
    step(0, 0, 0, 0, '0);
    chk("R2 load readback", 32'(rd_data), 32'h A5);
    chk("R3 valid", 32'(rd_valid), 1);
    step(1, 3'd3, 2, 8'h00, '0);
    step(0, 0, 0, 0, '0);
    chk("R4 swap to live", 32'(live_q[2*W +: W]), 32'hA5);

    // atomic test on node 0 with pattern 0x81, functional enable off
    step(1, 3'd1, 0, 8'h81, '0);
    step(1, 3'd4, 0, 8'h00, '0);
    step(1, 3'd1, 0, 8'hFF, '1);   // dropped: busy (R6), fen on for R8
    chk("R5 busy rises", 32'(busy), 1);
    step(1, 3'd1, 0, 8'hEE, '0);
    step(0, 0, 0, 0, '0);
    step(0, 0, 0, 0, '0);
    chk("R5 busy done", 32'(busy), 0);
    chk("R5 live restored", 32'(live_q[0 +: W]), 0);
    step(1, 3'd2, 0, 8'h00, '0);
    step(0, 0, 0, 0, '0);
    chk("R5 response", 32'(rd_data), 32'(resp(8'h81, 0)));

    // out-of-range select
    step(1, 3'd1, 6, 8'h11, '0);
    step(0, 0, 0, 0, '0);
    chk("R7 err pulse", 32'(err), 1);
    step(1, 3'd6, 7, 8'h11, '0);
    step(0, 0, 0, 0, '0);
    chk("R7 no err unused code", 32'(err), 0);

    // random phase
    void'($urandom(32'd4242));
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) op = 3'd4;
      step(1'($urandom_range(0, 1)), op, SEL_W'($urandom_range(0, 7)),
           W'($urandom), NODES'($urandom));
    end
    step(0, 0, 0, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule